// File: doc/BRIEF.md
# Transmit Descriptor Run Sequencer

This block is the control state machine of a descriptor-driven transmit DMA engine. Software gives it a list base address and a single run bit. When the run bit is set while the engine is idle, the block reads the descriptor at its current position through a simple request/acknowledge handshake. That handshake returns an ownership bit and an end-of-ring bit. If the DMA owns the descriptor, the block waits for the data path to report that the frame is finished. It then steps its descriptor pointer by a fixed stride, or jumps back to the list base when the descriptor was marked as the last one in the ring.

If the block finds a descriptor that the DMA does not own, it parks in a Suspended state and raises a sticky buffer-unavailable flag. A poll pulse makes it read the same descriptor again. Clearing the run bit never cuts a frame short. The engine stops once the frame in flight completes, and it stops at once if it is suspended. The pointer it holds at that moment is kept, so a later restart resumes from there rather than from the base.

Top module: `txdma_seq`

## Requirements
- R1: After reset, `run_state` is 0 (Stopped), `desc_req` is 0, `buf_unavail` is 0 and `desc_addr` is 0.
- R2: On the first start after reset (`run_en` high while Stopped), the next cycle shows `run_state` 1 (Running), `desc_req` high and `desc_addr` equal to `list_base`.
- R3: `desc_req` stays high with a stable `desc_addr` until `desc_ack`. An owned descriptor (`desc_own`=1) drops `desc_req` while the engine stays Running. A `frame_done` pulse then issues a request at the previous address plus STRIDE.
- R4: When the accepted descriptor had `desc_eor`=1, the request after its `frame_done` is at `list_base`.
- R5: A descriptor acknowledged with `desc_own`=0 moves the engine to `run_state` 2 (Suspended) with `desc_req` low and `buf_unavail` set.
- R6: `buf_unavail` stays set until a `bu_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: A `poll_req` pulse while Suspended requests the same descriptor address again. If that descriptor is now owned, the engine returns to Running.
- R8: If `run_en` is cleared during a frame, the engine stays Running until `frame_done`. It then goes to Stopped with no new request, and `desc_addr` holds the advanced position.
- R9: If `run_en` is low while Suspended, the engine goes to Stopped on the next clock edge.
- R10: A restart after a stop requests the saved position and ignores the current `list_base` value.
- R11: `poll_req` outside Suspended, and `frame_done` outside a frame transfer, change neither the state nor `desc_addr`.
- R12: If `run_en` is low when a pending request is acknowledged, the engine goes to Stopped, keeps its pointer and leaves `buf_unavail` unchanged, whatever the ownership bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run bit: 1 = start or keep running, 0 = stop request |
| list_base | input | AW | Descriptor ring base address |
| poll_req | input | 1 | Poll pulse that re-reads the descriptor while Suspended |
| bu_clr | input | 1 | Write-one-to-clear strobe for `buf_unavail` |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | AW | Current descriptor pointer |
| desc_ack | input | 1 | Descriptor read response valid |
| desc_own | input | 1 | Ownership bit of the returned descriptor (1 = DMA) |
| desc_eor | input | 1 | End-of-ring bit of the returned descriptor |
| frame_done | input | 1 | Pulse: the current frame has finished |
| run_state | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |

## Verification
A wrong state shows at `run_state` and `desc_req` one cycle after the handshake or command that should have moved it. A wrong pointer shows on `desc_addr` at the very next fetch request, one edge after `frame_done`, poll or restart. Sweeping ring lengths one to four against addresses computed as base plus index times stride exposes any off-by-one in the stride or in the wrap. Stop and restart sequences catch a pointer that is lost or reloaded from the base.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    S_STOP  = 2'd0,
    S_FETCH = 2'd1,
    S_SUSP  = 2'd2,
    S_XFER  = 2'd3
  } seq_st_t;

  localparam logic [1:0] RS_STOPPED   = 2'd0;
  localparam logic [1:0] RS_RUNNING   = 2'd1;
  localparam logic [1:0] RS_SUSPENDED = 2'd2;
endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    run_en,
  input  logic    poll_req,
  input  logic    desc_ack,
  input  logic    desc_own,
  input  logic    frame_done,
  output seq_st_t st,
  output logic    load_base,
  output logic    accept,
  output logic    advance,
  output logic    miss
);
  logic started;

  always_comb begin
    load_base = (st == S_STOP) && run_en && !started;
    accept    = (st == S_FETCH) && desc_ack && desc_own && run_en;
    miss      = (st == S_FETCH) && desc_ack && !desc_own && run_en;
    advance   = (st == S_XFER) && frame_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_STOP;
      started <= 1'b0;
    end else begin
      case (st)
        S_STOP: begin
          if (run_en) begin
            st      <= S_FETCH;
            started <= 1'b1;
          end
        end
        S_FETCH: begin
          if (desc_ack) begin
            if (!run_en)       st <= S_STOP;
            else if (desc_own) st <= S_XFER;
            else               st <= S_SUSP;
          end
        end
        S_XFER: begin
          if (frame_done) st <= run_en ? S_FETCH : S_STOP;
        end
        S_SUSP: begin
          if (!run_en)       st <= S_STOP;
          else if (poll_req) st <= S_FETCH;
        end
        default: st <= S_STOP;
      endcase
    end
  end

  // R8: a frame in flight is never abandoned
  a_r8_frame_holds: assert property (@(posedge clk) disable iff (rst)
    (st == S_XFER && !frame_done) |=> (st == S_XFER));

  // R9: stop while suspended is immediate
  a_r9_susp_stop: assert property (@(posedge clk) disable iff (rst)
    (st == S_SUSP && !run_en) |=> (st == S_STOP));

  // R5: unowned descriptor suspends
  a_r5_unowned: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH && desc_ack && !desc_own && run_en) |=> (st == S_SUSP));
endmodule

// File: rtl/txdma_ptr.sv
module txdma_ptr #(
  parameter int AW     = 16,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          load_base,
  input  logic          accept,
  input  logic          eor_in,
  input  logic          advance,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] STEP = AW'(STRIDE);

  logic eor_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      eor_q <= 1'b0;
    end else begin
      if (accept) eor_q <= eor_in;
      if (load_base)    ptr <= base;
      else if (advance) ptr <= eor_q ? base : ptr + STEP;
    end
  end

  // R4: end-of-ring returns to the base
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (advance && eor_q) |=> (ptr == $past(base)));
endmodule

// File: rtl/txdma_stat.sv
module txdma_stat (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R6: sticky until cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
  import txdma_pkg::*;
#(
  parameter int AW     = 16,
  parameter int STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic [AW-1:0] list_base,
  input  logic          poll_req,
  input  logic          bu_clr,
  output logic          desc_req,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_ack,
  input  logic          desc_own,
  input  logic          desc_eor,
  input  logic          frame_done,
  output logic [1:0]    run_state,
  output logic          buf_unavail
);
  seq_st_t st;
  logic    load_base, accept, advance, miss;

  txdma_ctrl u_ctrl (
    .clk(clk), .rst(rst), .run_en(run_en), .poll_req(poll_req),
    .desc_ack(desc_ack), .desc_own(desc_own), .frame_done(frame_done),
    .st(st), .load_base(load_base), .accept(accept),
    .advance(advance), .miss(miss)
  );

  txdma_ptr #(.AW(AW), .STRIDE(STRIDE)) u_ptr (
    .clk(clk), .rst(rst), .base(list_base), .load_base(load_base),
    .accept(accept), .eor_in(desc_eor), .advance(advance), .ptr(desc_addr)
  );

  txdma_stat u_stat (
    .clk(clk), .rst(rst), .set_i(miss), .clr_i(bu_clr), .flag_o(buf_unavail)
  );

  always_comb begin
    desc_req = (st == S_FETCH);
    case (st)
      S_STOP:  run_state = RS_STOPPED;
      S_SUSP:  run_state = RS_SUSPENDED;
      default: run_state = RS_RUNNING;
    endcase
  end

  // R3: pending request holds its address
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (desc_req && !desc_ack) |=> (desc_req && $stable(desc_addr)));

  // R5: flag rises only from a missed fetch
  a_r5_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_unavail) |-> (run_state == RS_SUSPENDED));
endmodule

// File: tb/txdma_seq_bench.sv
module txdma_seq_bench;
  localparam int AW = 8;
  localparam int STRIDE = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic          poll_req = 1'b0;
  logic          bu_clr = 1'b0;
  logic          desc_ack = 1'b0;
  logic          desc_own = 1'b0;
  logic          desc_eor = 1'b0;
  logic          frame_done = 1'b0;
  logic          desc_req;
  logic [AW-1:0] desc_addr;
  logic [1:0]    run_state;
  logic          buf_unavail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  txdma_seq #(.AW(AW), .STRIDE(STRIDE)) u_txdma_seq (
    .clk(clk), .rst(rst), .run_en(run_en), .list_base(list_base),
    .poll_req(poll_req), .bu_clr(bu_clr), .desc_req(desc_req),
    .desc_addr(desc_addr), .desc_ack(desc_ack), .desc_own(desc_own),
    .desc_eor(desc_eor), .frame_done(frame_done),
    .run_state(run_state), .buf_unavail(buf_unavail)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic respond(input logic own, input logic eor);
    desc_ack = 1'b1; desc_own = own; desc_eor = eor;
    tick();
    desc_ack = 1'b0; desc_own = 1'b0; desc_eor = 1'b0;
  endtask

  task automatic finish_frame();
    frame_done = 1'b1;
    tick();
    frame_done = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; run_en = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  initial begin
    int base;
    int saved;
    #1;
    do_reset();
    // R1: reset state
    chk("R1 state", run_state, 0);
    chk("R1 req", desc_req, 0);
    chk("R1 flag", buf_unavail, 0);
    chk("R1 addr", desc_addr, 0);

    // R2/R3/R4: sweep ring lengths
    for (int n = 1; n <= 4; n++) begin
      do_reset();
      base = 8'h20 + n * 8'h10;
      list_base = AW'(base);
      run_en = 1'b1;
      tick();
      chk("R2 state", run_state, 1);
      chk("R2 req", desc_req, 1);
      chk("R2 addr", desc_addr, base);
      for (int f = 0; f < 2 * n + 1; f++) begin
        chk("R3/R4 addr", desc_addr, (base + (f % n) * STRIDE) % 256);
        tick();
        chk("R3 hold", desc_addr, (base + (f % n) * STRIDE) % 256);
        chk("R3 hold req", desc_req, 1);
        respond(1'b1, (f % n) == n - 1);
        chk("R3 xfer state", run_state, 1);
        chk("R3 xfer req", desc_req, 0);
        finish_frame();
        chk("R3 next req", desc_req, 1);
      end
    end

    // R11: poll during a transfer is ignored
    saved = desc_addr;
    respond(1'b1, 1'b0);
    poll_req = 1'b1; tick(); poll_req = 1'b0;
    chk("R11 poll state", run_state, 1);
    chk("R11 poll req", desc_req, 0);
    chk("R11 poll addr", desc_addr, saved);
    finish_frame();
    saved = (saved + STRIDE) % 256;
    chk("R3 addr", desc_addr, saved);

    // R5: unowned descriptor
    respond(1'b0, 1'b0);
    chk("R5 state", run_state, 2);
    chk("R5 req", desc_req, 0);
    chk("R5 flag", buf_unavail, 1);
    // R11: frame_done in Suspended ignored
    finish_frame();
    chk("R11 fd state", run_state, 2);
    chk("R11 fd addr", desc_addr, saved);
    // R6: sticky
    repeat (3) tick();
    chk("R6 sticky", buf_unavail, 1);
    // R7: poll re-reads same descriptor
    poll_req = 1'b1; tick(); poll_req = 1'b0;
    chk("R7 req", desc_req, 1);
    chk("R7 addr", desc_addr, saved);
    respond(1'b0, 1'b0);
    chk("R7 resusp", run_state, 2);
    bu_clr = 1'b1; tick(); bu_clr = 1'b0;
    chk("R6 clear", buf_unavail, 0);
    poll_req = 1'b1; tick(); poll_req = 1'b0;
    // R6: set wins over clear
    bu_clr = 1'b1;
    respond(1'b0, 1'b0);
    bu_clr = 1'b0;
    chk("R6 set wins", buf_unavail, 1);
    poll_req = 1'b1; tick(); poll_req = 1'b0;
    respond(1'b1, 1'b0);
    chk("R7 running", run_state, 1);
    chk("R7 req low", desc_req, 0);

    // R8: stop deferred to end of frame
    run_en = 1'b0;
    repeat (3) tick();
    chk("R8 still running", run_state, 1);
    finish_frame();
    saved = (saved + STRIDE) % 256;
    chk("R8 stopped", run_state, 0);
    chk("R8 no req", desc_req, 0);
    chk("R8 saved addr", desc_addr, saved);
    tick();
    chk("R8 stays stopped", run_state, 0);

    // R10: restart from saved position
    list_base = 8'h08;
    run_en = 1'b1;
    tick();
    chk("R10 req", desc_req, 1);
    chk("R10 addr", desc_addr, saved);

    // R9: stop in Suspended
    respond(1'b0, 1'b0);
    chk("R9 susp", run_state, 2);
    run_en = 1'b0;
    tick();
    chk("R9 stopped", run_state, 0);
    chk("R9 addr", desc_addr, saved);
    run_en = 1'b1;
    tick();
    chk("R10 restart addr", desc_addr, saved);

    // R12: stop while a request is pending
    bu_clr = 1'b1; tick(); bu_clr = 1'b0;
    run_en = 1'b0;
    tick();
    chk("R12 pending", desc_req, 1);
    respond(1'b0, 1'b0);
    chk("R12 stopped", run_state, 0);
    chk("R12 flag untouched", buf_unavail, 0);
    chk("R12 addr", desc_addr, saved);
    run_en = 1'b1;
    tick();
    chk("R12 restart", desc_addr, saved);
    chk("R12 restart req", desc_req, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule